// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small in-order CPU core and decides when the core should leave its instruction stream to serve an interrupt. It watches a set of request inputs, each built either as an event source that leaves a sticky flag or as a level source that requests only while its input is high. It holds one enable bit per source and tracks a single global enable. Acceptance happens only at an instruction boundary, which the core marks with a retire strobe. When a request is taken, the block clears the global enable and the flag it served, emits an acknowledge pulse carrying the vector number, and raises a fetch strobe a fixed number of cycles later.

The core reports the retirement of return-from-interrupt, set-enable and clear-enable instructions on side strobes that come with the retire strobe. Return and set-enable arm the global enable and force one more instruction to retire before any request is taken. Clear-enable blocks acceptance in its own retire cycle. Software clears flags by writing ones, and can re-arm the global enable inside a handler to allow nesting.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all flags, all enables and the global enable are 0, `ack_o` and `fetch_o` are 0 and `vec_o` is 0.
- R2: A source that is not in `LEVEL_MASK` sets its bit of `flag_o` one cycle after its `src_i` bit is high, whatever the enables hold, and keeps it until served or cleared. For a level source (bit set in `LEVEL_MASK`), `flag_o` reads 0.
- R3: In a cycle with `flag_clr_we_i` high, each flag whose `flag_clr_i` bit is 1 clears and each with a 0 bit is unchanged. A flag event in the same cycle wins over the clear.
- R4: A request is accepted only in a cycle with `retire_i` high, the global enable at 1, and the source's enable bit (written through `en_we_i`/`en_wdata_i`) at 1.
- R5: Among accepted candidates, the lowest source index wins. `vec_o` carries that index plus 1, because vector 0 is reserved for reset.
- R6: Acceptance in cycle T gives `ack_o` high for exactly cycle T+1 with `vec_o` valid. The global enable is 0 from T+1, and only the served source's flag clears.
- R7: `fetch_o` pulses in cycle T+`RESP_CYCLES` (4 by default), with `vec_o` unchanged. No other request is accepted from T+1 through T+`RESP_CYCLES`.
- R8: A retire with `reti_i` or `sei_i` high sets the global enable from the next cycle and accepts nothing in its own cycle, so a pending request is taken at the following retire at the earliest.
- R9: A retire with `cli_i` high accepts nothing and leaves the global enable 0 from the next cycle.
- R10: A level source requests only while its `src_i` bit is high. A pulse that ends before the enables allow it leaves nothing behind.
- R11: Once the global enable is set again inside a handler, any enabled pending source, including one of lower priority than the one being served, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NUM_SRC | Raw request conditions, one per source |
| flag_clr_we_i | input | 1 | Write strobe for flag clearing |
| flag_clr_i | input | NUM_SRC | Ones select the flags to clear |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NUM_SRC | New per-source enable values |
| retire_i | input | 1 | An instruction retires this cycle |
| reti_i | input | 1 | The retiring instruction is return-from-interrupt |
| sei_i | input | 1 | The retiring instruction sets the global enable |
| cli_i | input | 1 | The retiring instruction clears the global enable |
| flag_o | output | NUM_SRC | Current latched flags |
| en_o | output | NUM_SRC | Current per-source enables |
| gie_o | output | 1 | Current global enable |
| ack_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | VEC_W | Vector of the last accepted source |
| fetch_o | output | 1 | Vector fetch strobe at the end of the response window |

## Verification
A stale global enable shows up as an extra or missing `ack_o` at the very next retire strobe, so shadow and clear-enable faults surface within one instruction. A wrong priority pick or a flag cleared for the wrong source appears as a wrong `vec_o` at the acknowledge cycle, or as a flag left on `flag_o` one cycle later. A miscounted response window moves `fetch_o` off cycle T+4 or lets a second acknowledge into the window. Each of these stays visible for only a few cycles, so the scoreboard pins every acknowledge and fetch to an exact cycle number.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Response sequencer: waiting for a request, or counting toward vector fetch
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RESP = 1'b1
  } seq_state_e;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int unsigned NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic [NUM_SRC-1:0] serve_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we_i) begin
      en_q <= en_wdata_i;
    end
  end

  assign en_o = en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      // A level source keeps no state: it requests only while its input is high
      logic unused_lvl;
      assign unused_lvl = clr_i[i] ^ serve_i[i];
      assign flag_o[i]  = 1'b0;
      assign pend_o[i]  = src_i[i] & en_q[i];
    end else begin : g_flag
      logic flag_q;
      logic flag_d;

      // A new event beats both the software clear and the hardware clear
      always_comb begin
        flag_d = flag_q;
        if (serve_i[i])             flag_d = 1'b0;
        if (clr_we_i && clr_i[i])   flag_d = 1'b0;
        if (src_i[i])               flag_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
        end else begin
          flag_q <= flag_d;
        end
      end

      assign flag_o[i] = flag_q;
      assign pend_o[i] = flag_q & en_q[i];

      // R2
      flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_i[i] |=> flag_o[i]);
    end
  end

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 4
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o
);

  // Scan from the lowest priority upward so that the lowest index is written last
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = VEC_W'(i + 1);
      end
    end
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/irqc_gate_seq.sv
module irqc_gate_seq
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned VEC_W       = 4,
  parameter int unsigned RESP_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_i,
  input  logic               reti_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               any_i,
  input  logic [NUM_SRC-1:0] grant_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic [NUM_SRC-1:0] serve_o,
  output logic               gie_o,
  output logic               ack_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               fetch_o
);

  localparam int unsigned CNT_W = $clog2(RESP_CYCLES + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gie_q, gie_d;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;
  logic             accept;
  logic             shadow;

  // RETI and SEI push acceptance past one further instruction, and CLI acts in its own cycle
  assign shadow = reti_i | sei_i | cli_i;
  assign accept = (state_q == SEQ_IDLE) & retire_i & gie_q & any_i & ~shadow;
  assign serve_o = accept ? grant_i : '0;

  always_comb begin
    gie_d = gie_q;
    if (accept || (retire_i && cli_i)) begin
      gie_d = 1'b0;
    end else if (retire_i && (reti_i || sei_i)) begin
      gie_d = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          state_d = SEQ_RESP;
          cnt_d   = CNT_W'(RESP_CYCLES);
        end
      end
      SEQ_RESP: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          state_d = SEQ_IDLE;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      gie_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gie_q   <= gie_d;
      ack_q   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (accept) begin
      vec_q <= vec_i;
    end
  end

  assign gie_o   = gie_q;
  assign ack_o   = ack_q;
  assign vec_o   = vec_q;
  assign fetch_o = (state_q == SEQ_RESP) && (cnt_q == CNT_W'(1));

  // R4
  ack_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(gie_q));

  // R5
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (vec_q != '0));

  // R6
  entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !gie_q);

  // R8
  shadow_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && (reti_i || sei_i)) |=> !ack_q);

  // R9
  cli_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && cli_i) |=> (!ack_q && !gie_q));

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned NUM_SRC            = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK  = 8'hC0,
  parameter int unsigned RESP_CYCLES        = 4,
  localparam int unsigned VEC_W             = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               flag_clr_we_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               retire_i,
  input  logic               reti_i,
  input  logic               sei_i,
  input  logic               cli_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gie_o,
  output logic               ack_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               fetch_o
);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] serve;
  logic [VEC_W-1:0]   pick_vec;
  logic               any_pend;

  irqc_src_bank #(
    .NUM_SRC    (NUM_SRC),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .clr_we_i   (flag_clr_we_i),
    .clr_i      (flag_clr_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .serve_i    (serve),
    .flag_o     (flag_o),
    .en_o       (en_o),
    .pend_o     (pend)
  );

  irqc_prio_pick #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) u_pick (
    .pend_i  (pend),
    .any_o   (any_pend),
    .grant_o (grant),
    .vec_o   (pick_vec)
  );

  irqc_gate_seq #(
    .NUM_SRC     (NUM_SRC),
    .VEC_W       (VEC_W),
    .RESP_CYCLES (RESP_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .retire_i (retire_i),
    .reti_i   (reti_i),
    .sei_i    (sei_i),
    .cli_i    (cli_i),
    .any_i    (any_pend),
    .grant_i  (grant),
    .vec_i    (pick_vec),
    .serve_o  (serve),
    .gie_o    (gie_o),
    .ack_o    (ack_o),
    .vec_o    (vec_o),
    .fetch_o  (fetch_o)
  );

endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;

  localparam int N    = 8;
  localparam int RESP = 4;
  localparam int VW   = 4;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src_i;
  logic          flag_clr_we_i;
  logic [N-1:0]  flag_clr_i;
  logic          en_we_i;
  logic [N-1:0]  en_wdata_i;
  logic          retire_i, reti_i, sei_i, cli_i;
  logic [N-1:0]  flag_o, en_o;
  logic          gie_o, ack_o, fetch_o;
  logic [VW-1:0] vec_o;

  irq_vec_ctrl #(.NUM_SRC(N), .LEVEL_MASK(8'hC0), .RESP_CYCLES(RESP)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .flag_clr_we_i(flag_clr_we_i), .flag_clr_i(flag_clr_i),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
    .retire_i(retire_i), .reti_i(reti_i), .sei_i(sei_i), .cli_i(cli_i),
    .flag_o(flag_o), .en_o(en_o), .gie_o(gie_o), .ack_o(ack_o),
    .vec_o(vec_o), .fetch_o(fetch_o)
  );

  typedef struct {
    int v;
    int c;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   ack_count = 0;
  int   exp_acks = 0;
  int   last_ack_cyc = -100;
  int   last_vec = 0;
  bit   done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  // Monitor: every acknowledge is popped from the scoreboard and timed exactly
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ack_o) begin
        ack_count++;
        if (exp_q.size() == 0) begin
          chk("R4 unexpected acceptance (vec)", 32'(vec_o), 32'hFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R5 vector", 32'(vec_o), 32'(e.v));
          chk("R6 ack cycle", 32'(cyc), 32'(e.c));
        end
        last_ack_cyc = cyc;
        last_vec = int'(vec_o);
      end
      if (fetch_o) begin
        chk("R7 fetch cycle", 32'(cyc), 32'(last_ack_cyc + RESP - 1));
        chk("R7 fetch vector", 32'(vec_o), 32'(last_vec));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic pulse_src(input logic [N-1:0] m);
    step();
    src_i = m;
    step();
    src_i = '0;
  endtask

  task automatic clr(input logic [N-1:0] m);
    step();
    flag_clr_we_i = 1'b1;
    flag_clr_i = m;
    step();
    flag_clr_we_i = 1'b0;
    flag_clr_i = '0;
  endtask

  task automatic wen(input logic [N-1:0] m);
    step();
    en_we_i = 1'b1;
    en_wdata_i = m;
    step();
    en_we_i = 1'b0;
  endtask

  // kind: 0 plain, 1 set-enable, 2 return, 3 clear-enable; ev = expected vector or 0 for none
  task automatic retire(input int kind, input int ev);
    step();
    retire_i = 1'b1;
    sei_i  = (kind == 1);
    reti_i = (kind == 2);
    cli_i  = (kind == 3);
    if (ev != 0) begin
      exp_t e;
      e.v = ev;
      e.c = cyc + 1;
      exp_q.push_back(e);
      exp_acks++;
    end
    step();
    retire_i = 1'b0;
    sei_i = 1'b0;
    reti_i = 1'b0;
    cli_i = 1'b0;
  endtask

  task automatic chk_noack(input string tag);
    idle(1);
    chk(tag, 32'(ack_count), 32'(exp_acks));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_i = '0;
    flag_clr_we_i = 1'b0;
    flag_clr_i = '0;
    en_we_i = 1'b0;
    en_wdata_i = '0;
    retire_i = 1'b0;
    reti_i = 1'b0;
    sei_i = 1'b0;
    cli_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 enables", 32'(en_o), 0);
    chk("R1 gie", 32'(gie_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
    chk("R1 fetch", 32'(fetch_o), 0);
    chk("R1 vec", 32'(vec_o), 0);

    // R2 latching while disabled; level source leaves no flag
    pulse_src(8'h08);
    chk("R2 flag latched while disabled", 32'(flag_o), 32'h08);
    pulse_src(8'h40);
    chk("R2 level source has no flag", 32'(flag_o), 32'h08);

    // R3 write-one-to-clear
    clr(8'h20);
    chk("R3 zero bit leaves flag", 32'(flag_o), 32'h08);
    clr(8'h08);
    chk("R3 one bit clears flag", 32'(flag_o), 32'h00);
    step();
    src_i = 8'h04;
    flag_clr_we_i = 1'b1;
    flag_clr_i = 8'h04;
    step();
    src_i = '0;
    flag_clr_we_i = 1'b0;
    flag_clr_i = '0;
    chk("R3 event wins over clear", 32'(flag_o), 32'h04);
    clr(8'h04);

    // R4 gating by global enable
    pulse_src(8'h0A);
    wen(8'hFF);
    chk("R4 enables written", 32'(en_o), 32'hFF);
    retire(0, 0);
    idle(5);
    chk_noack("R4 no acceptance with global enable low");

    // R8 set-enable shadow, then R5 priority
    retire(1, 0);
    chk_noack("R8 no acceptance at set-enable retire");
    chk("R8 gie set", 32'(gie_o), 1);
    retire(0, 2);
    idle(6);
    chk("R6 gie cleared on entry", 32'(gie_o), 0);
    chk("R6 only served flag cleared", 32'(flag_o), 32'h08);
    retire(0, 0);
    chk_noack("R4 no acceptance inside handler");
    retire(2, 0);
    chk_noack("R8 no acceptance at return retire");
    chk("R8 gie set by return", 32'(gie_o), 1);
    retire(0, 4);
    idle(6);
    chk("R6 flags empty", 32'(flag_o), 0);

    // R7 busy window and R11 nesting by a lower-priority source
    pulse_src(8'h22);
    retire(2, 0);
    retire(0, 2);
    retire(1, 0);
    retire(0, 0);
    chk_noack("R7 no acceptance during response window");
    retire(0, 6);
    idle(6);
    chk("R11 nested source served", 32'(flag_o), 0);

    // R4 local enable gates; R2 flag kept while disabled
    wen(8'hEF);
    pulse_src(8'h10);
    retire(1, 0);
    retire(0, 0);
    chk_noack("R4 no acceptance with source disabled");
    chk("R2 flag kept while disabled", 32'(flag_o), 32'h10);
    wen(8'hFF);
    retire(0, 5);
    idle(6);

    // R9 clear-enable right after return
    pulse_src(8'h01);
    retire(2, 0);
    retire(3, 0);
    chk_noack("R9 no acceptance at clear-enable retire");
    chk("R9 gie cleared", 32'(gie_o), 0);
    retire(0, 0);
    chk_noack("R9 still nothing taken");
    chk("R9 flag still pending", 32'(flag_o), 32'h01);
    clr(8'h01);

    // R10 level source: no memory, then served while held
    step();
    src_i = 8'h40;
    idle(3);
    src_i = '0;
    retire(1, 0);
    retire(0, 0);
    chk_noack("R10 vanished level request not taken");
    step();
    src_i = 8'h40;
    retire(0, 7);
    src_i = '0;
    idle(6);

    // R5 two flags, served one at a time in index order
    pulse_src(8'h0C);
    retire(2, 0);
    retire(0, 3);
    idle(5);
    chk("R5 lower index served first", 32'(flag_o), 32'h08);
    retire(2, 0);
    retire(0, 4);
    idle(8);

    chk("R5 scoreboard drained", 32'(exp_q.size()), 0);
    chk("R4 total acceptances", 32'(ack_count), 32'(exp_acks));

    done = 1;
    summary();
    $finish;
  end

endmodule